// File: doc/BRIEF.md
# Glitch-free clock stop controller

This block makes the gated copies of a set of clock outputs: a processor-rate group, a bus-rate group with one member that never stops, a memory-clock group that also runs at processor rate, and one reference output. Every output is a register driven from one fast master clock. Internal phase dividers produce the free-running processor, bus and reference waveforms. The gating decides, per output, whether that waveform reaches the pin.

Three requests come in on pins that may change at any time: power-down, processor stop and bus stop. They pass through a two-stage synchronizer first. The mode input controls how three memory-clock pins are used. With the mode low they are request inputs and their clock outputs are held low. With the mode high they are ordinary clocks and every request is treated as inactive.

A byte-wide configuration bank holds one active-high enable bit per output. The processor-stop path waits a set number of processor falling edges before it acts. The bus-stop path acts at the next bus rising edge. Power-down forces everything low and, once released, holds the outputs low for a settle count of reference cycles. Every change between gated and running happens while the output is low, so no output ever gives a shortened high pulse.

Top module: `clk_stop_ctrl`

## Requirements
- R1: While `rst_n` is low, every clock output is low. After reset, every implemented enable bit reads back as 1.
- R2: Each phase starts low after reset and toggles every HALF master ticks, where HALF is CPU_HALF for the processor clock, BUS_HALF for the bus clock and REF_HALF for the reference clock. The processor and memory outputs follow the processor phase, the bus outputs follow the bus phase and the reference output follows the reference phase. Each output is registered, and its value after a clock edge equals the phase after that edge AND the gating state after that edge.
- R3: With `mode_i` low, `shared_pin_i` bit 0 is the power-down request, bit 1 is the processor-stop request and bit 2 is the bus-stop request, all active high. In this mode the memory outputs SHARED_BASE, SHARED_BASE+1 and SHARED_BASE+2 are held low. With `mode_i` high, all requests are inactive.
- R4: Each request acts only after passing through two master-clock register stages.
- R5: When the synchronized processor-stop request differs from the applied stop state, the new value is applied at the CPU_LAT-th processor falling edge, counted from the first falling edge at which the two differ. If the request returns to the applied state first, the count restarts. While the stop is applied, all processor outputs are low.
- R6: The synchronized bus-stop request is applied at the next bus-phase rising edge. While it is applied, bus outputs 0 to NBUS-2 are low. Bus output NBUS-1 keeps toggling.
- R7: A synchronized power-down request sets a hold that takes every output low at that output's next low phase, including the free bus output and the reference output. After the request is released, the hold clears at the SETTLE-th reference falling edge.
- R8: Enable bits are 1 = active and 0 = held low. Processor enables are in byte 0, bits [NCPU-1:0]. Bus enables are in byte 1, bits [NBUS-1:0]. Memory enables 7..0 are in byte 2, and memory enables NMEM-1..8 are in byte 3, starting at bit 0. The reference enable is byte 4, bit 0. A write takes effect on the next master edge, and the output follows at its next low phase.
- R9: Unimplemented bits and addresses 5 to 7 read as zero, and writing them changes no output.
- R10: An output rises only on the same edge as its phase rises, and falls only on the same edge as its phase falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | Low: shared pins carry the requests. High: shared pins are clocks |
| shared_pin_i | input | 3 | Request levels seen on the shared pins (power-down, processor stop, bus stop) |
| cfg_wr_i | input | 1 | Configuration byte write strobe |
| cfg_addr_i | input | 3 | Configuration byte address |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Configuration read data for the addressed byte |
| cpu_clk_o | output | NCPU | Processor-rate clock outputs |
| bus_clk_o | output | NBUS | Bus-rate clock outputs; the top bit is free-running |
| mem_clk_o | output | NMEM | Memory clock outputs at processor rate |
| ref_clk_o | output | 1 | Reference clock output |

## Verification
A request pin changed between edges reaches the synchronized level two edges later. Its effect on the outputs then waits for the group's own phase point: the CPU_LAT-th processor falling edge, the next bus rising edge, or the next low phase for enables and power-down. The settle release lands on the SETTLE-th reference falling edge. The bench model advances on every rising edge using the register values from before that edge, so it applies each of these delays in the same cycle as a correct design would. All outputs are compared at the falling edge, half a period after they settle. Fixed-window checks of held-low and free-running outputs are sampled only after the longest of these latencies has passed.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;
  localparam int CFG_AW = 3;
  localparam logic [CFG_AW-1:0] ADDR_CPU    = 3'd0;
  localparam logic [CFG_AW-1:0] ADDR_BUS    = 3'd1;
  localparam logic [CFG_AW-1:0] ADDR_MEM_LO = 3'd2;
  localparam logic [CFG_AW-1:0] ADDR_MEM_HI = 3'd3;
  localparam logic [CFG_AW-1:0] ADDR_REF    = 3'd4;
  localparam int REQ_PD  = 0;
  localparam int REQ_CPU = 1;
  localparam int REQ_BUS = 2;
  localparam int NREQ    = 3;
endpackage

// File: rtl/csc_phase_gen.sv
module csc_phase_gen #(
  parameter int HALF = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic ph_o,
  output logic ph_n_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q, cnt_n;
  logic          ph_q, ph_n;

  always_comb begin
    cnt_n = cnt_q + 1'b1;
    ph_n  = ph_q;
    if (cnt_q == CW'(HALF - 1)) begin
      cnt_n = '0;
      ph_n  = ~ph_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      ph_q  <= ph_n;
    end
  end

  assign ph_o   = ph_q;
  assign ph_n_o = ph_n;
  assign rise_o = ph_n & ~ph_q;
  assign fall_o = ph_q & ~ph_n;
endmodule

// File: rtl/csc_sync.sv
module csc_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;

  AST_SYNC_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |=> (q_o == $past(d_i, 2))); // R4
endmodule

// File: rtl/csc_cfg_bank.sv
module csc_cfg_bank
  import clk_stop_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int NBUS = 7,
  parameter int NMEM = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [CFG_AW-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic [NCPU-1:0]   cpu_en_o,
  output logic [NBUS-1:0]   bus_en_o,
  output logic [NMEM-1:0]   mem_en_o,
  output logic              ref_en_o
);
  localparam int MHI = NMEM - 8;

  logic [NCPU-1:0] cpu_q, cpu_n;
  logic [NBUS-1:0] bus_q, bus_n;
  logic [NMEM-1:0] mem_q, mem_n;
  logic            ref_q, ref_n;

  always_comb begin
    cpu_n = cpu_q;
    bus_n = bus_q;
    mem_n = mem_q;
    ref_n = ref_q;
    if (wr_i) begin
      case (addr_i)
        ADDR_CPU:    cpu_n = wdata_i[NCPU-1:0];
        ADDR_BUS:    bus_n = wdata_i[NBUS-1:0];
        ADDR_MEM_LO: mem_n[7:0] = wdata_i;
        ADDR_MEM_HI: mem_n[NMEM-1:8] = wdata_i[MHI-1:0];
        ADDR_REF:    ref_n = wdata_i[0];
        default:     ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_q <= '1;
      bus_q <= '1;
      mem_q <= '1;
      ref_q <= 1'b1;
    end else begin
      cpu_q <= cpu_n;
      bus_q <= bus_n;
      mem_q <= mem_n;
      ref_q <= ref_n;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_CPU:    rdata_o[NCPU-1:0] = cpu_q;
      ADDR_BUS:    rdata_o[NBUS-1:0] = bus_q;
      ADDR_MEM_LO: rdata_o = mem_q[7:0];
      ADDR_MEM_HI: rdata_o[MHI-1:0] = mem_q[NMEM-1:8];
      ADDR_REF:    rdata_o[0] = ref_q;
      default:     rdata_o = '0;
    endcase
  end

  assign cpu_en_o = cpu_q;
  assign bus_en_o = bus_q;
  assign mem_en_o = mem_q;
  assign ref_en_o = ref_q;

  AST_REF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == ADDR_REF) |=> (ref_en_o == $past(wdata_i[0]))); // R8
  AST_RESERVED_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i > ADDR_REF) |=> ($stable(cpu_en_o) && $stable(bus_en_o) &&
                                     $stable(mem_en_o) && $stable(ref_en_o))); // R9
endmodule

// File: rtl/csc_stop_seq.sv
module csc_stop_seq
  import clk_stop_pkg::*;
#(
  parameter int CPU_LAT = 2,
  parameter int SETTLE  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] req_s_i,
  input  logic            cpu_fall_i,
  input  logic            bus_rise_i,
  input  logic            ref_fall_i,
  output logic            cpu_stop_o,
  output logic            cpu_stop_n_o,
  output logic            bus_stop_o,
  output logic            bus_stop_n_o,
  output logic            pd_hold_o
);
  localparam int LCW = (CPU_LAT > 1) ? $clog2(CPU_LAT) : 1;
  localparam int SCW = (SETTLE > 1) ? $clog2(SETTLE) : 1;

  logic           cstop_q, cstop_n;
  logic [LCW-1:0] lcnt_q, lcnt_n;
  logic           bstop_q, bstop_n;
  logic           hold_q, hold_n;
  logic [SCW-1:0] scnt_q, scnt_n;

  always_comb begin
    cstop_n = cstop_q;
    lcnt_n  = lcnt_q;
    if (req_s_i[REQ_CPU] != cstop_q) begin
      if (cpu_fall_i) begin
        if (lcnt_q == LCW'(CPU_LAT - 1)) begin
          cstop_n = req_s_i[REQ_CPU];
          lcnt_n  = '0;
        end else begin
          lcnt_n = lcnt_q + 1'b1;
        end
      end
    end else begin
      lcnt_n = '0;
    end
  end

  always_comb begin
    bstop_n = bstop_q;
    if (bus_rise_i) begin
      bstop_n = req_s_i[REQ_BUS];
    end
  end

  always_comb begin
    hold_n = hold_q;
    scnt_n = scnt_q;
    if (req_s_i[REQ_PD]) begin
      hold_n = 1'b1;
      scnt_n = '0;
    end else if (hold_q && ref_fall_i) begin
      if (scnt_q == SCW'(SETTLE - 1)) begin
        hold_n = 1'b0;
        scnt_n = '0;
      end else begin
        scnt_n = scnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cstop_q <= 1'b0;
      lcnt_q  <= '0;
      bstop_q <= 1'b0;
      hold_q  <= 1'b0;
      scnt_q  <= '0;
    end else begin
      cstop_q <= cstop_n;
      lcnt_q  <= lcnt_n;
      bstop_q <= bstop_n;
      hold_q  <= hold_n;
      scnt_q  <= scnt_n;
    end
  end

  assign cpu_stop_o   = cstop_q;
  assign cpu_stop_n_o = cstop_n;
  assign bus_stop_o   = bstop_q;
  assign bus_stop_n_o = bstop_n;
  assign pd_hold_o    = hold_q;

  AST_CPU_STOP_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cstop_q) |-> $past(cpu_fall_i)); // R5
  AST_BUS_STOP_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bstop_q) |-> $past(bus_rise_i)); // R6
  AST_PD_HOLD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    req_s_i[REQ_PD] |=> hold_q); // R7
  AST_PD_HOLD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_q) |-> ($past(ref_fall_i) && !$past(req_s_i[REQ_PD]))); // R7
endmodule

// File: rtl/csc_out_gate.sv
module csc_out_gate #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ph_n_i,
  input  logic         hold_i,
  input  logic         stop_n_i,
  input  logic [W-1:0] en_i,
  output logic [W-1:0] clk_o
);
  logic [W-1:0] g_q, g_n;
  logic [W-1:0] o_q, o_n;
  logic         ph_q;

  always_comb begin
    g_n = g_q;
    if (!ph_n_i) begin
      g_n = en_i & ~{W{hold_i}};
    end
    o_n = {W{ph_n_i & ~stop_n_i}} & g_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g_q  <= '0;
      o_q  <= '0;
      ph_q <= 1'b0;
    end else begin
      g_q  <= g_n;
      o_q  <= o_n;
      ph_q <= ph_n_i;
    end
  end

  assign clk_o = o_q;

  for (genvar i = 0; i < W; i++) begin : g_chk
    AST_NO_RUNT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(o_q[i]) |-> $rose(ph_q)); // R10
    AST_NO_RUNT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(o_q[i]) |-> $fell(ph_q)); // R10
  end
endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl
  import clk_stop_pkg::*;
#(
  parameter int NCPU        = 4,
  parameter int NBUS        = 7,
  parameter int NMEM        = 12,
  parameter int CPU_HALF    = 1,
  parameter int BUS_HALF    = 2,
  parameter int REF_HALF    = 3,
  parameter int CPU_LAT     = 2,
  parameter int SETTLE      = 4,
  parameter int SHARED_BASE = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_i,
  input  logic [2:0]        shared_pin_i,
  input  logic              cfg_wr_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [7:0]        cfg_wdata_i,
  output logic [7:0]        cfg_rdata_o,
  output logic [NCPU-1:0]   cpu_clk_o,
  output logic [NBUS-1:0]   bus_clk_o,
  output logic [NMEM-1:0]   mem_clk_o,
  output logic              ref_clk_o
);
  localparam logic [NMEM-1:0] SHARED_MASK = NMEM'(7) << SHARED_BASE;
  localparam int NSTOP = NBUS - 1;

  logic cph, cph_n, crise, cfall;
  logic bph, bph_n, brise, bfall;
  logic rph, rph_n, rrise, rfall;

  logic [NREQ-1:0] req_raw, req_s;
  logic [NCPU-1:0] cpu_en;
  logic [NBUS-1:0] bus_en;
  logic [NMEM-1:0] mem_en, mem_en_eff;
  logic            ref_en;
  logic            cstop, cstop_n, bstop, bstop_n, pd_hold;

  csc_phase_gen #(.HALF(CPU_HALF)) u_cph (
    .clk(clk), .rst_n(rst_n), .ph_o(cph), .ph_n_o(cph_n), .rise_o(crise), .fall_o(cfall));
  csc_phase_gen #(.HALF(BUS_HALF)) u_bph (
    .clk(clk), .rst_n(rst_n), .ph_o(bph), .ph_n_o(bph_n), .rise_o(brise), .fall_o(bfall));
  csc_phase_gen #(.HALF(REF_HALF)) u_rph (
    .clk(clk), .rst_n(rst_n), .ph_o(rph), .ph_n_o(rph_n), .rise_o(rrise), .fall_o(rfall));

  assign req_raw = mode_i ? '0 : shared_pin_i;

  csc_sync #(.W(NREQ)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(req_raw), .q_o(req_s));

  csc_cfg_bank #(.NCPU(NCPU), .NBUS(NBUS), .NMEM(NMEM)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_i(cfg_wr_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .rdata_o(cfg_rdata_o), .cpu_en_o(cpu_en), .bus_en_o(bus_en), .mem_en_o(mem_en),
    .ref_en_o(ref_en));

  csc_stop_seq #(.CPU_LAT(CPU_LAT), .SETTLE(SETTLE)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_s_i(req_s), .cpu_fall_i(cfall), .bus_rise_i(brise),
    .ref_fall_i(rfall), .cpu_stop_o(cstop), .cpu_stop_n_o(cstop_n), .bus_stop_o(bstop),
    .bus_stop_n_o(bstop_n), .pd_hold_o(pd_hold));

  assign mem_en_eff = mem_en & ~(mode_i ? '0 : SHARED_MASK);

  csc_out_gate #(.W(NCPU)) u_gcpu (
    .clk(clk), .rst_n(rst_n), .ph_n_i(cph_n), .hold_i(pd_hold), .stop_n_i(cstop_n),
    .en_i(cpu_en), .clk_o(cpu_clk_o));
  csc_out_gate #(.W(NMEM)) u_gmem (
    .clk(clk), .rst_n(rst_n), .ph_n_i(cph_n), .hold_i(pd_hold), .stop_n_i(1'b0),
    .en_i(mem_en_eff), .clk_o(mem_clk_o));
  csc_out_gate #(.W(NSTOP)) u_gbus (
    .clk(clk), .rst_n(rst_n), .ph_n_i(bph_n), .hold_i(pd_hold), .stop_n_i(bstop_n),
    .en_i(bus_en[NSTOP-1:0]), .clk_o(bus_clk_o[NSTOP-1:0]));
  csc_out_gate #(.W(1)) u_gfree (
    .clk(clk), .rst_n(rst_n), .ph_n_i(bph_n), .hold_i(pd_hold), .stop_n_i(1'b0),
    .en_i(bus_en[NBUS-1]), .clk_o(bus_clk_o[NBUS-1]));
  csc_out_gate #(.W(1)) u_gref (
    .clk(clk), .rst_n(rst_n), .ph_n_i(rph_n), .hold_i(pd_hold), .stop_n_i(1'b0),
    .en_i(ref_en), .clk_o(ref_clk_o));

  AST_CPU_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cstop |-> (cpu_clk_o == '0)); // R5
  AST_BUS_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    bstop |-> (bus_clk_o[NSTOP-1:0] == '0)); // R6
  AST_PD_CPU_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_hold && $past(pd_hold) && !cph) |-> (cpu_clk_o == '0 && mem_clk_o == '0)); // R7
endmodule

// File: tb/clk_stop_ctrl_tb.sv
module clk_stop_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCPU = 4, NBUS = 7, NMEM = 12;
  localparam int CPU_HALF = 1, BUS_HALF = 2, REF_HALF = 3;
  localparam int CPU_LAT = 2, SETTLE = 4, SHARED_BASE = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_i = 1'b1;
  logic [2:0] shared_pin_i = 3'b000;
  logic cfg_wr_i = 1'b0;
  logic [2:0] cfg_addr_i = 3'd0;
  logic [7:0] cfg_wdata_i = 8'd0;
  logic [7:0] cfg_rdata_o;
  logic [NCPU-1:0] cpu_clk_o;
  logic [NBUS-1:0] bus_clk_o;
  logic [NMEM-1:0] mem_clk_o;
  logic ref_clk_o;

  int checks = 0;
  int failures = 0;
  string tag = "R2";
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_stop_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .shared_pin_i(shared_pin_i),
    .cfg_wr_i(cfg_wr_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
    .cfg_rdata_o(cfg_rdata_o), .cpu_clk_o(cpu_clk_o), .bus_clk_o(bus_clk_o),
    .mem_clk_o(mem_clk_o), .ref_clk_o(ref_clk_o));

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", t, act, exp, $time);
    end
  endtask

  // behavioural reference state
  int cc, bc, rc;
  bit pc, pb, pr;
  bit [2:0] s1, s2;
  bit ceff, beff, hold;
  int lat_cnt, set_cnt;
  bit [NCPU-1:0] gc, en_c;
  bit [NMEM-1:0] gm, en_m;
  bit [NBUS-1:0] gb, en_b;
  bit gr, en_r;
  bit [NCPU-1:0] exp_c;
  bit [NBUS-1:0] exp_b;
  bit [NMEM-1:0] exp_m;
  bit exp_r;

  always @(posedge clk) begin
    if (!rst_n) begin
      cc = 0; bc = 0; rc = 0; pc = 0; pb = 0; pr = 0; s1 = 0; s2 = 0;
      ceff = 0; beff = 0; hold = 0; lat_cnt = 0; set_cnt = 0;
      gc = 0; gm = 0; gb = 0; gr = 0;
      en_c = '1; en_m = '1; en_b = '1; en_r = 1;
      exp_c = 0; exp_b = 0; exp_m = 0; exp_r = 0;
    end else begin
      automatic bit npc = pc, npb = pb, npr = pr;
      automatic bit fall_c, rise_b, fall_r, nceff, nbeff, nhold;
      automatic bit [NMEM-1:0] shm;
      if (cc == CPU_HALF-1) begin npc = !pc; cc = 0; end else cc++;
      if (bc == BUS_HALF-1) begin npb = !pb; bc = 0; end else bc++;
      if (rc == REF_HALF-1) begin npr = !pr; rc = 0; end else rc++;
      fall_c = pc && !npc; rise_b = !pb && npb; fall_r = pr && !npr;
      nceff = ceff;
      if (s2[1] != ceff) begin
        if (fall_c) begin
          if (lat_cnt == CPU_LAT-1) begin nceff = s2[1]; lat_cnt = 0; end
          else lat_cnt++;
        end
      end else lat_cnt = 0;
      nbeff = rise_b ? s2[2] : beff;
      nhold = hold;
      if (s2[0]) begin nhold = 1; set_cnt = 0; end
      else if (hold && fall_r) begin
        if (set_cnt == SETTLE-1) begin nhold = 0; set_cnt = 0; end else set_cnt++;
      end
      shm = '0;
      if (!mode_i) for (int k = 0; k < 3; k++) shm[SHARED_BASE+k] = 1'b1;
      if (!npc) begin
        gc = hold ? '0 : en_c;
        gm = hold ? '0 : (en_m & ~shm);
      end
      if (!npb) gb = hold ? '0 : en_b;
      if (!npr) gr = hold ? 1'b0 : en_r;
      if (cfg_wr_i) begin
        case (cfg_addr_i)
          3'd0: en_c = cfg_wdata_i[NCPU-1:0];
          3'd1: en_b = cfg_wdata_i[NBUS-1:0];
          3'd2: en_m[7:0] = cfg_wdata_i;
          3'd3: en_m[NMEM-1:8] = cfg_wdata_i[NMEM-9:0];
          3'd4: en_r = cfg_wdata_i[0];
          default: ;
        endcase
      end
      s2 = s1;
      s1 = mode_i ? 3'b000 : shared_pin_i;
      pc = npc; pb = npb; pr = npr; ceff = nceff; beff = nbeff; hold = nhold;
      exp_c = (pc && !ceff) ? gc : '0;
      exp_m = pc ? gm : '0;
      exp_b = pb ? gb : '0;
      if (beff) exp_b[NBUS-2:0] = '0;
      exp_r = pr && gr;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({tag, " cpu"}, 32'(cpu_clk_o), 32'(exp_c));
      chk({tag, " bus"}, 32'(bus_clk_o), 32'(exp_b));
      chk({tag, " mem"}, 32'(mem_clk_o), 32'(exp_m));
      chk({tag, " ref"}, 32'(ref_clk_o), 32'(exp_r));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [7:0] d);
    cfg_addr_i = a; cfg_wdata_i = d; cfg_wr_i = 1'b1;
    tick(1);
    cfg_wr_i = 1'b0;
  endtask

  task automatic cfg_read(input string t, input logic [2:0] a, input logic [7:0] e);
    cfg_addr_i = a;
    #1;
    chk(t, 32'(cfg_rdata_o), 32'(e));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int toggles;
    bit prev;
    tick(3);
    // R1: outputs low during reset, enables read as ones
    chk("R1 reset outputs", 32'({cpu_clk_o, bus_clk_o, mem_clk_o, ref_clk_o}), 32'd0);
    cfg_read("R1 cpu enables", 3'd0, 8'h0F);
    cfg_read("R1 bus enables", 3'd1, 8'h7F);
    cfg_read("R1 mem low enables", 3'd2, 8'hFF);
    cfg_read("R1 mem high enables", 3'd3, 8'h0F);
    cfg_read("R1 ref enable", 3'd4, 8'h01);
    cfg_read("R9 empty address", 3'd6, 8'h00);
    tick(1);
    rst_n = 1'b1;
    tag = "R2";
    tick(40);
    // R3: shared pins become inputs
    tag = "R3";
    mode_i = 1'b0;
    tick(10);
    for (int i = 0; i < 6; i++) begin
      chk("R3 shared pins low", 32'(mem_clk_o[SHARED_BASE +: 3]), 32'd0);
      tick(1);
    end
    // R5: processor stop, including a one-tick glitch
    tag = "R4";
    shared_pin_i[1] = 1'b1; tick(1); shared_pin_i[1] = 1'b0; tick(12);
    tag = "R5";
    #3 shared_pin_i[1] = 1'b1;
    tick(14);
    for (int i = 0; i < 6; i++) begin
      chk("R5 cpu held low", 32'(cpu_clk_o), 32'd0);
      tick(1);
    end
    shared_pin_i[1] = 1'b0;
    tick(20);
    // R6: bus stop, free clock keeps running
    tag = "R6";
    shared_pin_i[2] = 1'b1;
    tick(12);
    toggles = 0; prev = bus_clk_o[NBUS-1];
    for (int i = 0; i < 20; i++) begin
      chk("R6 stoppable bus low", 32'(bus_clk_o[NBUS-2:0]), 32'd0);
      if (bus_clk_o[NBUS-1] != prev) toggles++;
      prev = bus_clk_o[NBUS-1];
      tick(1);
    end
    chk("R6 free bus toggles", 32'(toggles), 32'd10);
    shared_pin_i[2] = 1'b0;
    tick(20);
    // R3: mode high ignores request levels
    tag = "R3";
    mode_i = 1'b1;
    shared_pin_i = 3'b111;
    tick(30);
    shared_pin_i = 3'b000;
    mode_i = 1'b0;
    tick(10);
    // R7: power-down then settle
    tag = "R7";
    shared_pin_i[0] = 1'b1;
    tick(14);
    for (int i = 0; i < 8; i++) begin
      chk("R7 all low", 32'({cpu_clk_o, bus_clk_o, mem_clk_o, ref_clk_o}), 32'd0);
      tick(1);
    end
    shared_pin_i[0] = 1'b0;
    tick(12);
    chk("R7 still settling", 32'({cpu_clk_o, bus_clk_o, mem_clk_o, ref_clk_o}), 32'd0);
    tick(50);
    // R8: enable mask
    tag = "R8";
    cfg_write(3'd0, 8'h0D);
    cfg_write(3'd1, 8'h3E);
    cfg_write(3'd3, 8'h00);
    cfg_write(3'd4, 8'h00);
    cfg_read("R8 cpu readback", 3'd0, 8'h0D);
    tick(20);
    chk("R8 cpu bit1 off", 32'(cpu_clk_o[1]), 32'd0);
    chk("R8 ref off", 32'(ref_clk_o), 32'd0);
    // R9: reserved bits and addresses
    tag = "R9";
    cfg_write(3'd0, 8'hF0);
    cfg_read("R9 cpu reserved zero", 3'd0, 8'h00);
    cfg_write(3'd4, 8'hFE);
    cfg_read("R9 ref reserved zero", 3'd4, 8'h00);
    cfg_write(3'd5, 8'hFF);
    cfg_write(3'd7, 8'hFF);
    cfg_read("R9 address 5 zero", 3'd5, 8'h00);
    cfg_read("R9 address 7 zero", 3'd7, 8'h00);
    tick(20);
    tag = "R8";
    cfg_write(3'd0, 8'hFF);
    cfg_write(3'd1, 8'hFF);
    cfg_write(3'd3, 8'hFF);
    cfg_write(3'd4, 8'hFF);
    cfg_read("R9 bus readback", 3'd1, 8'h7F);
    tag = "R10";
    tick(30);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule